// File: doc/BRIEF.md
# MSI Coherence Directory

This block is the central bookkeeping point for MSI cache coherence among up to sixteen cores. For every tracked line it keeps a protocol state, a bit mask of sharing cores and an owning core. Requests and replies from the cores enter an internal FIFO queue. The queue is served at one message per cycle. The block answers each message by emitting a single coherence message toward the cores. Memory is modelled only by its latency. A read from memory freezes the whole queue until the data reply leaves the block. Cache-to-cache transfers always pass through the directory: it recalls the line from its owner, receives the owner's data and forwards it to the requester. Three counters record memory reads, dirty writebacks and cache-to-cache transfers.

A message that targets a line still waiting on acknowledgements or data cannot be handled yet. It is taken off the head and appended again at the tail, so traffic for other lines keeps moving. Writebacks never stall the block; they only advance the write counter.

Top module: `msi_directory`

## Requirements
- R1: After reset no output message is valid, all three counters read zero, the queue is empty, every line is in state I and memory is idle.
- R2: At most one queued message is consumed per cycle, in arrival order. A message that needs no memory produces its output message one cycle after it was pushed into an empty queue. Input kind codes are 0 = GETS, 1 = GETM, 2 = INVACK, 3 = DATA. Pushing while `queue_full` is high is not allowed.
- R3: A GETS to a line in I or S, or a GETM to a line in I, starts a memory read and adds one to `mem_reads`. The DATA reply (output kind 0) goes to the requester MEM_LAT+1 cycles after the push. The line then ends in S with the requester added, or in M owned by the requester. Output destinations are bit masks in which bit i selects core i.
- R4: While a memory read is pending, no queued message is consumed. The first queued message is handled in the cycle after the data reply.
- R5: A GETS or GETM for a line waiting on acknowledgements or data is moved to the tail of the queue and produces no output. A message pushed in the same cycle lands behind the moved one.
- R6: A GETS to a line in M sends RECALL_GOTO_S (kind 2) to the owner. When the owner's DATA arrives, the directory forwards DATA to the requester and adds one to `c2c_xfers` and to `mem_writes`. The line ends in S with both cores as sharers.
- R7: A GETM to a line in M sends RECALL_GOTO_I (kind 3) to the owner. The forwarded DATA adds one to `c2c_xfers` only, and the requester becomes the owner.
- R8: A GETM to a line in S with other sharers sends one REQ_INVALID (kind 1) whose mask lists every sharer except the requester. It grants only when the number of INVACKs equals the number of those sharers; earlier INVACKs produce no output.
- R9: If that GETM requester was not a sharer, the final INVACK starts a memory read (R3 timing from the INVACK push) in place of an immediate grant.
- R10: A GETM from the only sharer of a line in S gets DATA at once, with no memory read.
- R11: An INVACK or DATA for a line that is not waiting for one is consumed with no output and no change to the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Write a message into the queue |
| push_kind | input | 2 | Incoming message kind |
| push_src | input | $clog2(CORES) | Sending core |
| push_line | input | $clog2(LINES) | Line index |
| queue_full | output | 1 | Queue holds QDEPTH messages |
| mem_busy | output | 1 | Memory read in progress |
| msg_valid | output | 1 | Output message valid this cycle |
| msg_kind | output | 2 | Output message kind |
| msg_dest | output | CORES | Destination core mask |
| msg_line | output | $clog2(LINES) | Line index of output message |
| mem_reads | output | CNTW | Memory read count |
| mem_writes | output | CNTW | Dirty writeback count |
| c2c_xfers | output | CNTW | Cache-to-cache transfer count |

## Verification
The queue can receive a new message in the very cycle it moves a blocked head message to its tail, so the two writes compete for the tail slot. The bench parks a GETS behind a pending recall, where it cycles round every cycle, and then pushes the owner's DATA. A forwarded DATA exactly two cycles after the push, followed one cycle later by the recall for the parked GETS, shows that the recycled entry took the slot ahead of the newcomer. A second collision, a memory reply against a waiting head, is judged by the exact cycle of the head's reply.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;
  typedef enum logic [1:0] {IN_GETS = 2'd0, IN_GETM = 2'd1, IN_INVACK = 2'd2, IN_DATA = 2'd3} in_kind_e;
  typedef enum logic [1:0] {OUT_DATA = 2'd0, OUT_INVAL = 2'd1, OUT_RECALL_S = 2'd2, OUT_RECALL_I = 2'd3} out_kind_e;
  typedef enum logic [2:0] {ST_I, ST_S, ST_M, ST_SM_ACK, ST_M_DATA} line_state_e;
endpackage

// File: rtl/msi_dir_fifo.sv
module msi_dir_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic [W-1:0] push_data,
  input  logic         pop_en,
  input  logic         recyc_en,
  input  logic [W-1:0] recyc_data,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0] slots [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0] count;
  logic push_ok;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign head    = slots[rd_ptr];
  assign push_ok = push_en && !full;

  // recycled head takes the tail slot first, a new arrival goes behind it
  always_ff @(posedge clk) begin
    if (recyc_en) slots[wr_ptr] <= recyc_data;
    if (push_ok) begin
      if (recyc_en) slots[wr_ptr + AW'(1)] <= push_data;
      else          slots[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr + AW'(pop_en);
      wr_ptr <= wr_ptr + AW'(recyc_en) + AW'(push_ok);
      count  <= count + (AW+1)'(push_ok) - (AW+1)'(pop_en && !recyc_en);
    end
  end
endmodule

// File: rtl/msi_dir_memtimer.sv
module msi_dir_memtimer #(
  parameter int LAT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] remain;

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remain <= '0;
    else if (start)      remain <= CW'(LAT);
    else if (busy)       remain <= remain - CW'(1);
  end
endmodule

// File: rtl/msi_directory.sv
module msi_directory
  import msi_dir_pkg::*;
#(
  parameter int CORES   = 16,
  parameter int LINES   = 16,
  parameter int QDEPTH  = 8,
  parameter int MEM_LAT = 100,
  parameter int CNTW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid,
  input  logic [1:0]               push_kind,
  input  logic [$clog2(CORES)-1:0] push_src,
  input  logic [$clog2(LINES)-1:0] push_line,
  output logic                     queue_full,
  output logic                     mem_busy,
  output logic                     msg_valid,
  output logic [1:0]               msg_kind,
  output logic [CORES-1:0]         msg_dest,
  output logic [$clog2(LINES)-1:0] msg_line,
  output logic [CNTW-1:0]          mem_reads,
  output logic [CNTW-1:0]          mem_writes,
  output logic [CNTW-1:0]          c2c_xfers
);
  localparam int SRCW  = $clog2(CORES);
  localparam int LINEW = $clog2(LINES);
  localparam int QW    = 2 + SRCW + LINEW;
  localparam int ACKW  = $clog2(CORES + 1);

  function automatic logic [CORES-1:0] bit_of(input logic [SRCW-1:0] idx);
    return CORES'(1) << idx;
  endfunction

  function automatic logic [ACKW-1:0] pop_cnt(input logic [CORES-1:0] v);
    logic [ACKW-1:0] n = '0;
    for (int i = 0; i < CORES; i++) n = n + ACKW'(v[i]);
    return n;
  endfunction

  // directory table
  line_state_e      st    [LINES];
  logic [CORES-1:0] shr   [LINES];
  logic [SRCW-1:0]  own   [LINES];
  logic [SRCW-1:0]  preq  [LINES];
  logic             pgets [LINES];
  logic             pneed [LINES];
  logic [ACKW-1:0]  acks  [LINES];

  // pending memory read
  logic [LINEW-1:0] m_line;
  logic [SRCW-1:0]  m_req;
  logic             m_to_m;

  // queue and named events
  logic [QW-1:0] head;
  logic q_empty, head_ok;
  logic ev_pop, ev_recyc, ev_mem_start, ev_mem_done, ev_wr, ev_c2c;
  in_kind_e         h_kind;
  logic [SRCW-1:0]  h_src;
  logic [LINEW-1:0] h_line;

  msi_dir_fifo #(.W(QW), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_valid), .push_data({push_kind, push_src, push_line}),
    .pop_en(ev_pop), .recyc_en(ev_recyc), .recyc_data(head),
    .head(head), .empty(q_empty), .full(queue_full)
  );

  msi_dir_memtimer #(.LAT(MEM_LAT)) u_mem (
    .clk(clk), .rst_n(rst_n), .start(ev_mem_start),
    .busy(mem_busy), .done(ev_mem_done)
  );

  assign h_kind  = in_kind_e'(head[QW-1 -: 2]);
  assign h_src   = head[LINEW +: SRCW];
  assign h_line  = head[LINEW-1:0];
  assign head_ok = !q_empty && !mem_busy;

  // next-state of the single line touched this cycle
  logic             upd;
  logic [LINEW-1:0] u_line;
  line_state_e      u_st;
  logic [CORES-1:0] u_shr, others;
  logic [SRCW-1:0]  u_own, u_preq, ms_req;
  logic             u_pgets, u_pneed, ms_to_m;
  logic [ACKW-1:0]  u_acks;
  logic             n_valid;
  out_kind_e        n_kind;
  logic [CORES-1:0] n_dest;

  assign u_line = ev_mem_done ? m_line : h_line;
  assign others = shr[h_line] & ~bit_of(h_src);

  always_comb begin
    n_valid = 1'b0;  n_kind = OUT_DATA;  n_dest = '0;
    ev_pop = 1'b0;   ev_recyc = 1'b0;    ev_mem_start = 1'b0;
    ev_wr = 1'b0;    ev_c2c = 1'b0;
    ms_req = h_src;  ms_to_m = 1'b0;     upd = 1'b0;
    u_st = st[u_line];     u_shr = shr[u_line];     u_own = own[u_line];
    u_preq = preq[u_line]; u_pgets = pgets[u_line]; u_pneed = pneed[u_line];
    u_acks = acks[u_line];
    if (ev_mem_done) begin
      upd = 1'b1; n_valid = 1'b1; n_kind = OUT_DATA; n_dest = bit_of(m_req);
      if (m_to_m) begin u_st = ST_M; u_own = m_req; u_shr = '0; end
      else begin u_st = ST_S; u_shr = shr[m_line] | bit_of(m_req); end
    end else if (head_ok) begin
      ev_pop = 1'b1;
      case (h_kind)
        IN_GETS: case (st[h_line])
          ST_I, ST_S: ev_mem_start = 1'b1;
          ST_M: begin
            n_valid = 1'b1; n_kind = OUT_RECALL_S; n_dest = bit_of(own[h_line]);
            upd = 1'b1; u_st = ST_M_DATA; u_preq = h_src; u_pgets = 1'b1;
          end
          default: ev_recyc = 1'b1;
        endcase
        IN_GETM: case (st[h_line])
          ST_I: begin ev_mem_start = 1'b1; ms_to_m = 1'b1; end
          ST_S: begin
            upd = 1'b1; n_valid = 1'b1;
            if (others == '0) begin
              n_kind = OUT_DATA; n_dest = bit_of(h_src);
              u_st = ST_M; u_own = h_src; u_shr = '0;
            end else begin
              n_kind = OUT_INVAL; n_dest = others;
              u_st = ST_SM_ACK; u_acks = pop_cnt(others); u_preq = h_src;
              u_pneed = !shr[h_line][h_src];
            end
          end
          ST_M: begin
            n_valid = 1'b1; n_kind = OUT_RECALL_I; n_dest = bit_of(own[h_line]);
            upd = 1'b1; u_st = ST_M_DATA; u_preq = h_src; u_pgets = 1'b0;
          end
          default: ev_recyc = 1'b1;
        endcase
        IN_INVACK: if (st[h_line] == ST_SM_ACK) begin
          upd = 1'b1;
          if (acks[h_line] == ACKW'(1)) begin
            u_acks = '0;
            if (pneed[h_line]) begin
              ev_mem_start = 1'b1; ms_req = preq[h_line]; ms_to_m = 1'b1;
            end else begin
              n_valid = 1'b1; n_kind = OUT_DATA; n_dest = bit_of(preq[h_line]);
              u_st = ST_M; u_own = preq[h_line]; u_shr = '0;
            end
          end else u_acks = acks[h_line] - ACKW'(1);
        end
        IN_DATA: if (st[h_line] == ST_M_DATA) begin
          ev_c2c = 1'b1; upd = 1'b1;
          n_valid = 1'b1; n_kind = OUT_DATA; n_dest = bit_of(preq[h_line]);
          if (pgets[h_line]) begin
            ev_wr = 1'b1; u_st = ST_S;
            u_shr = bit_of(own[h_line]) | bit_of(preq[h_line]);
          end else begin
            u_st = ST_M; u_own = preq[h_line]; u_shr = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= ST_I; shr[i] <= '0; own[i] <= '0; preq[i] <= '0;
        pgets[i] <= 1'b0; pneed[i] <= 1'b0; acks[i] <= '0;
      end
      m_line <= '0; m_req <= '0; m_to_m <= 1'b0;
      msg_valid <= 1'b0; msg_kind <= '0; msg_dest <= '0; msg_line <= '0;
      mem_reads <= '0; mem_writes <= '0; c2c_xfers <= '0;
    end else begin
      if (upd) begin
        st[u_line] <= u_st; shr[u_line] <= u_shr; own[u_line] <= u_own;
        preq[u_line] <= u_preq; pgets[u_line] <= u_pgets;
        pneed[u_line] <= u_pneed; acks[u_line] <= u_acks;
      end
      if (ev_mem_start) begin
        m_line <= h_line; m_req <= ms_req; m_to_m <= ms_to_m;
      end
      msg_valid <= n_valid;
      msg_kind  <= n_kind;
      msg_dest  <= n_dest;
      msg_line  <= u_line;
      mem_reads  <= mem_reads + CNTW'(ev_mem_start);
      mem_writes <= mem_writes + CNTW'(ev_wr);
      c2c_xfers  <= c2c_xfers + CNTW'(ev_c2c);
    end
  end
endmodule

// File: rtl/msi_dir_checker.sv
module msi_dir_checker
  import msi_dir_pkg::*;
#(
  parameter int CORES   = 16,
  parameter int MEM_LAT = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             queue_full,
  input logic             mem_busy,
  input logic             ev_pop,
  input logic             ev_recyc,
  input logic             ev_mem_start,
  input logic             ev_mem_done,
  input logic             ev_c2c,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [CORES-1:0] msg_dest
);
  localparam int LW = $clog2(MEM_LAT + 1) + 1;
  logic [LW-1:0] lat;
  logic trk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0; trk <= 1'b0;
    end else begin
      if (ev_mem_start) begin lat <= '0; trk <= 1'b1; end
      else if (ev_mem_done) trk <= 1'b0;
      else if (trk) lat <= lat + LW'(1);
      if (ev_mem_done)
        assert_mem_latency_R3: assert (trk && lat == LW'(MEM_LAT - 1));
    end
  end

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !ev_pop);
  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_start |-> !mem_busy);
  assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |-> !push_valid);
  assert_recycle_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_recyc |=> !msg_valid);
  assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_c2c |=> (msg_valid && msg_kind == 2'(OUT_DATA) && $countones(msg_dest) == 1));
  assert_data_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'(OUT_DATA)) |-> $countones(msg_dest) == 1);
  assert_inval_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'(OUT_INVAL)) |-> msg_dest != '0);
endmodule

bind msi_directory msi_dir_checker #(.CORES(CORES), .MEM_LAT(MEM_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .queue_full(queue_full),
  .mem_busy(mem_busy), .ev_pop(ev_pop), .ev_recyc(ev_recyc),
  .ev_mem_start(ev_mem_start), .ev_mem_done(ev_mem_done), .ev_c2c(ev_c2c),
  .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest)
);

// File: tb/msi_directory_bench.sv
module msi_directory_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 100;
  localparam logic [1:0] GETS = 2'd0, GETM = 2'd1, INVACK = 2'd2, DATA = 2'd3;
  localparam logic [1:0] O_DATA = 2'd0, O_INV = 2'd1, O_RS = 2'd2, O_RI = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [1:0] push_kind = '0;
  logic [3:0] push_src = '0, push_line = '0;
  logic queue_full, mem_busy, msg_valid;
  logic [1:0] msg_kind;
  logic [15:0] msg_dest;
  logic [3:0] msg_line;
  logic [15:0] mem_reads, mem_writes, c2c_xfers;

  int cyc = 0, t_last = 0, n_chk = 0, n_fail = 0;
  int exp_rd = 0, exp_wr = 0, exp_c2c = 0;

  msi_directory u_msi_directory (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_kind(push_kind),
    .push_src(push_src), .push_line(push_line), .queue_full(queue_full),
    .mem_busy(mem_busy), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .msg_line(msg_line), .mem_reads(mem_reads),
    .mem_writes(mem_writes), .c2c_xfers(c2c_xfers)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m(input int c);
    return 16'(1) << c;
  endfunction

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic push(input logic [1:0] k, input int src, input int line);
    push_valid = 1'b1; push_kind = k; push_src = 4'(src); push_line = 4'(line);
    @(posedge clk); @(negedge clk);
    push_valid = 1'b0; t_last = cyc;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic expect_msg(input int target, input logic [1:0] k, input logic [15:0] dest,
                            input int line, input string tag);
    logic [22:0] act, exp;
    wait_to(target);
    act = {msg_valid, msg_kind, msg_dest, msg_line};
    exp = {1'b1, k, dest, 4'(line)};
    chk(act == exp && cyc == target, tag, 64'(act), 64'(exp));
  endtask

  task automatic expect_quiet(input int target, input string tag);
    wait_to(target);
    chk(!msg_valid, tag, 64'(msg_valid), 64'd0);
  endtask

  task automatic check_counts(input string tag);
    chk(mem_reads == 16'(exp_rd), {tag, " reads"}, 64'(mem_reads), 64'(exp_rd));
    chk(mem_writes == 16'(exp_wr), {tag, " writes"}, 64'(mem_writes), 64'(exp_wr));
    chk(c2c_xfers == 16'(exp_c2c), {tag, " c2c"}, 64'(c2c_xfers), 64'(exp_c2c));
  endtask

  task automatic t_reset;  // R1
    chk(!msg_valid && !mem_busy && !queue_full, "R1 idle outputs",
        64'({msg_valid, mem_busy, queue_full}), 64'd0);
    check_counts("R1");
  endtask

  task automatic t_fill_and_upgrade;  // R3, R10
    push(GETS, 2, 1); exp_rd++;
    expect_msg(t_last + LAT + 1, O_DATA, m(2), 1, "R3 read fill");
    push(GETM, 2, 1);
    expect_msg(t_last + 1, O_DATA, m(2), 1, "R10 sole sharer upgrade");
    check_counts("R10");
  endtask

  task automatic t_stall;  // R4
    int t0;
    push(GETS, 3, 2); exp_rd++;
    expect_msg(t_last + LAT + 1, O_DATA, m(3), 2, "R4 setup");
    push(GETS, 0, 8); exp_rd++; t0 = t_last;
    push(GETM, 3, 2);
    expect_quiet(t0 + 2, "R4 head frozen");
    expect_msg(t0 + LAT + 1, O_DATA, m(0), 8, "R4 memory reply");
    expect_msg(t0 + LAT + 2, O_DATA, m(3), 2, "R4 resume after reply");
  endtask

  task automatic t_recall_recycle;  // R5, R6, R7, R8, R9
    int t0;
    push(GETM, 0, 3); exp_rd++;
    expect_msg(t_last + LAT + 1, O_DATA, m(0), 3, "R3 GETM fill");
    push(GETM, 1, 3);
    expect_msg(t_last + 1, O_RI, m(0), 3, "R7 recall to I");
    push(GETS, 2, 3);
    expect_quiet(t_last + 1, "R5 recycled GETS silent");
    expect_quiet(t_last + 3, "R5 still parked");
    push(DATA, 0, 3); exp_c2c++; t0 = t_last;
    expect_msg(t0 + 2, O_DATA, m(1), 3, "R7 forward after recycle (R5 order)");
    expect_msg(t0 + 3, O_RS, m(1), 3, "R5 parked GETS then recalls");
    check_counts("R7");
    push(DATA, 1, 3); exp_c2c++; exp_wr++;
    expect_msg(t_last + 1, O_DATA, m(2), 3, "R6 forward to reader");
    check_counts("R6");
    push(GETM, 3, 3);
    expect_msg(t_last + 1, O_INV, m(1) | m(2), 3, "R6 both cores share");
    push(INVACK, 1, 3);
    expect_quiet(t_last + 1, "R8 first ack silent");
    push(INVACK, 2, 3); exp_rd++;
    expect_msg(t_last + LAT + 1, O_DATA, m(3), 3, "R9 non-sharer reads memory");
    check_counts("R9");
  endtask

  task automatic t_invalidate;  // R2, R8
    int t0;
    push(GETS, 0, 5); exp_rd++;
    push(GETS, 1, 5); exp_rd++;
    push(GETS, 2, 5); exp_rd++;
    wait_to(t_last + 3 * LAT + 6);
    push(GETM, 1, 5);
    expect_msg(t_last + 1, O_INV, m(0) | m(2), 5, "R8 mask skips requester");
    push(INVACK, 0, 5); t0 = t_last;
    push(INVACK, 2, 5);
    expect_quiet(t0 + 1, "R8 early ack silent");
    expect_msg(t0 + 2, O_DATA, m(1), 5, "R2 back-to-back acks, R8 grant");
    check_counts("R8");
  endtask

  task automatic t_stray;  // R11
    push(INVACK, 4, 9);
    expect_quiet(t_last + 1, "R11 stray ack");
    push(DATA, 4, 9);
    expect_quiet(t_last + 1, "R11 stray data");
    check_counts("R11");
    push(GETS, 6, 9); exp_rd++;
    expect_msg(t_last + LAT + 1, O_DATA, m(6), 9, "R11 line still I");
    check_counts("R11 final");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_upgrade();
    t_stall();
    t_recall_recycle();
    t_invalidate();
    t_stray();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule